// File: doc/BRIEF.md
# PCI Power-State Tracker

This block follows the bus power-management state of a PCI function that runs as a target on the bus. When the external host writes the two-bit PowerState field of the function's power management control/status register, the configuration path gives the block a one-cycle write strobe and the written field value. The block moves between six states: D0 before software initialization, D0 after it, D1, D2, D3hot, and D3cold. D3cold is entered only when the local supply is reported lost.

Local software sees the current PowerState code on a status output. It also sees a sticky change flag, which every host write that alters PowerState will set. A local write of one clears the flag. The flag drives an interrupt line through a local enable bit. Software uses the flag to react after the host has moved the function to another power level. It also signals, through a one-cycle pulse, that it has finished initializing the function in D0.

Top module: `pci_pm_tracker`

## Requirements
- R1: An asynchronous low `rst_n`, or a synchronous high `bus_rst` or `ctrl_rst`, puts the block in uninitialized D0: `ps`=2'b00, `uninit`=1, `d3cold`=0, `chg_flag`=0, `irq_en`=0, visible one clock after a synchronous reset is sampled.
- R2: A `sw_init` pulse in uninitialized D0 moves the state to initialized D0 (`uninit`=0, `ps`=2'b00). In any other state, `sw_init` has no effect. A host write in the same cycle takes priority over `sw_init`.
- R3: A host write (`cfg_wr`=1) of `cfg_ps` 2'b01, 2'b10 or 2'b11 moves the state to D1, D2 or D3hot. `ps` reports the code of the current state: 2'b00 for either D0, 2'b01 for D1, 2'b10 for D2, and 2'b11 for D3hot or D3cold.
- R4: A host write of 2'b00 from D3hot returns the state to uninitialized D0. From D1 or D2, the same write goes to initialized D0.
- R5: A host write whose value differs from the current `ps` sets `chg_flag` on the next clock. A write of the value already held changes neither the state nor the flag.
- R6: `clr_wr`=1 clears `chg_flag`. When a flag-setting write arrives in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when both `chg_flag` and `irq_en` are high. `irq_en` loads `irq_en_wdata` on a cycle with `irq_en_wr`=1.
- R8: `vcc_cut`=1 forces D3cold (`d3cold`=1, `ps`=2'b11) and takes priority over host writes and `sw_init`. D3cold ignores host writes and `sw_init`, and it is left only through the R1 resets. `vcc_cut` does not alter `chg_flag`.
- R9: A synchronous reset takes priority over `vcc_cut` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_rst | input | 1 | PCI bus reset, synchronous, active high |
| ctrl_rst | input | 1 | Controller hardware reset, synchronous, active high |
| vcc_cut | input | 1 | Supply lost indication |
| cfg_wr | input | 1 | Host write strobe to the PowerState field |
| cfg_ps | input | 2 | PowerState value written by the host |
| sw_init | input | 1 | Software initialization done pulse |
| clr_wr | input | 1 | Local write-one-to-clear of the change flag |
| irq_en_wr | input | 1 | Local write strobe for the interrupt enable |
| irq_en_wdata | input | 1 | Value for the interrupt enable |
| ps | output | 2 | Current PowerState code |
| uninit | output | 1 | High in uninitialized D0 |
| d3cold | output | 1 | High in D3cold |
| chg_flag | output | 1 | Sticky state-change flag |
| irq_en | output | 1 | Interrupt enable bit |
| irq | output | 1 | State-change interrupt |

## Verification
The properties assume that every input is a clean synchronous level sampled once per clock edge, with `cfg_wr` as a one-cycle strobe whose `cfg_ps` is valid in that cycle. They also assume the resets may coincide with any other input. Because the ordering between resets, `vcc_cut`, host writes and `sw_init` is part of the contract, each property lists the higher-priority inputs it excludes. The bench drives every input only at the falling edge, each value held for exactly one cycle. It sweeps every reachable starting state against every written code, with and without a concurrent `sw_init`, clear and enable write. Separate directed cycles cover reset and supply-loss collisions.

// File: rtl/pci_pm_pkg.sv
package pci_pm_pkg;

    localparam int PS_W   = 2;
    localparam int ST_W   = 3;

    localparam logic [PS_W-1:0] PS_D0 = PS_W'(0);
    localparam logic [PS_W-1:0] PS_D1 = PS_W'(1);
    localparam logic [PS_W-1:0] PS_D2 = PS_W'(2);
    localparam logic [PS_W-1:0] PS_D3 = PS_W'(3);

    typedef enum logic [ST_W-1:0] {
        ST_D0_UNINIT = 3'd0,
        ST_D0_ACT    = 3'd1,
        ST_D1        = 3'd2,
        ST_D2        = 3'd3,
        ST_D3HOT     = 3'd4,
        ST_D3COLD    = 3'd5
    } pm_state_e;

    typedef struct packed {
        pm_state_e st;
    } fsm_regs_t;

    typedef struct packed {
        logic chg;
        logic en;
    } stat_regs_t;

    function automatic logic [PS_W-1:0] ps_of(pm_state_e s);
        case (s)
            ST_D1:               return PS_D1;
            ST_D2:               return PS_D2;
            ST_D3HOT, ST_D3COLD: return PS_D3;
            default:             return PS_D0;
        endcase
    endfunction

endpackage

// File: rtl/pm_write_decode.sv
module pm_write_decode
    import pci_pm_pkg::*;
(
    input  pm_state_e        cur_st,
    input  logic             wr_en,
    input  logic [PS_W-1:0]  wr_ps,
    output logic             hit,
    output pm_state_e        tgt_st
);

    logic [PS_W-1:0] cur_ps;

    always_comb begin
        cur_ps = ps_of(cur_st);
        // a write counts only when it alters the visible code and power is present
        hit    = wr_en && (cur_st != ST_D3COLD) && (wr_ps != cur_ps);
        case (wr_ps)
            PS_D1:   tgt_st = ST_D1;
            PS_D2:   tgt_st = ST_D2;
            PS_D3:   tgt_st = ST_D3HOT;
            default: tgt_st = (cur_st == ST_D3HOT) ? ST_D0_UNINIT : ST_D0_ACT;
        endcase
    end

endmodule

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pci_pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_rst,
    input  logic       vcc_cut,
    input  logic       hit,
    input  pm_state_e  tgt_st,
    input  logic       sw_init,
    output pm_state_e  state
);

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (sync_rst) begin
            regs_d.st = ST_D0_UNINIT;
        end else if (vcc_cut) begin
            regs_d.st = ST_D3COLD;
        end else if (hit) begin
            regs_d.st = tgt_st;
        end else if (sw_init && (regs_q.st == ST_D0_UNINIT)) begin
            regs_d.st = ST_D0_ACT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st <= ST_D0_UNINIT;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state = regs_q.st;

endmodule

// File: rtl/pm_chg_status.sv
module pm_chg_status
    import pci_pm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_rst,
    input  logic set_chg,
    input  logic clr_wr,
    input  logic en_wr,
    input  logic en_wdata,
    output logic chg_q,
    output logic en_q
);

    stat_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (sync_rst) begin
            regs_d = '0;
        end else begin
            // setting wins over a concurrent clear
            if (set_chg) begin
                regs_d.chg = 1'b1;
            end else if (clr_wr) begin
                regs_d.chg = 1'b0;
            end
            if (en_wr) begin
                regs_d.en = en_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign chg_q = regs_q.chg;
    assign en_q  = regs_q.en;

endmodule

// File: rtl/pci_pm_tracker.sv
module pci_pm_tracker
    import pci_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             ctrl_rst,
    input  logic             vcc_cut,
    input  logic             cfg_wr,
    input  logic [PS_W-1:0]  cfg_ps,
    input  logic             sw_init,
    input  logic             clr_wr,
    input  logic             irq_en_wr,
    input  logic             irq_en_wdata,
    output logic [PS_W-1:0]  ps,
    output logic             uninit,
    output logic             d3cold,
    output logic             chg_flag,
    output logic             irq_en,
    output logic             irq
);

    logic      sync_rst;
    logic      wr_hit;
    logic      set_chg;
    pm_state_e tgt_st;
    pm_state_e cur_st;

    assign sync_rst = bus_rst | ctrl_rst;
    assign set_chg  = wr_hit & ~vcc_cut;

    pm_write_decode u_dec (
        .cur_st (cur_st),
        .wr_en  (cfg_wr),
        .wr_ps  (cfg_ps),
        .hit    (wr_hit),
        .tgt_st (tgt_st)
    );

    pm_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_rst (sync_rst),
        .vcc_cut  (vcc_cut),
        .hit      (wr_hit),
        .tgt_st   (tgt_st),
        .sw_init  (sw_init),
        .state    (cur_st)
    );

    pm_chg_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_rst (sync_rst),
        .set_chg  (set_chg),
        .clr_wr   (clr_wr),
        .en_wr    (irq_en_wr),
        .en_wdata (irq_en_wdata),
        .chg_q    (chg_flag),
        .en_q     (irq_en)
    );

    assign ps     = ps_of(cur_st);
    assign uninit = (cur_st == ST_D0_UNINIT);
    assign d3cold = (cur_st == ST_D3COLD);
    assign irq    = chg_flag & irq_en;

endmodule

// File: rtl/pci_pm_tracker_chk.sv
module pci_pm_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rst,
    input logic       ctrl_rst,
    input logic       vcc_cut,
    input logic       cfg_wr,
    input logic [1:0] cfg_ps,
    input logic       sw_init,
    input logic       clr_wr,
    input logic       irq_en_wr,
    input logic       irq_en_wdata,
    input logic [1:0] ps,
    input logic       uninit,
    input logic       d3cold,
    input logic       chg_flag,
    input logic       irq_en,
    input logic       irq
);

    logic quiet;
    assign quiet = !bus_rst && !ctrl_rst;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst || ctrl_rst) |=> (uninit && ps == 2'b00 && !d3cold && !chg_flag && !irq_en)); // R1

    AST_INIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !vcc_cut && uninit && sw_init && !cfg_wr) |=> (!uninit && ps == 2'b00)); // R2

    AST_D3HOT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !vcc_cut && !d3cold && cfg_wr && cfg_ps == 2'b11) |=> (ps == 2'b11 && !d3cold)); // R3

    AST_D3_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !vcc_cut && !d3cold && ps == 2'b11 && cfg_wr && cfg_ps == 2'b00) |=> uninit); // R4

    AST_CHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !vcc_cut && !d3cold && cfg_wr && cfg_ps != ps) |=> chg_flag); // R5

    AST_CHG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && clr_wr && !cfg_wr) |=> !chg_flag); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R7

    AST_COLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && d3cold) |=> (d3cold && ps == 2'b11)); // R8

    AST_VCC_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && vcc_cut) |=> d3cold); // R8

    AST_RESET_OVER_VCC: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_cut && bus_rst) |=> (uninit && !d3cold)); // R9

endmodule

bind pci_pm_tracker pci_pm_tracker_chk chk_i (.*);

// File: tb/pci_pm_tracker_tb.sv
module pci_pm_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0, ctrl_rst = 1'b0, vcc_cut = 1'b0;
    logic       cfg_wr = 1'b0, sw_init = 1'b0, clr_wr = 1'b0;
    logic       irq_en_wr = 1'b0, irq_en_wdata = 1'b0;
    logic [1:0] cfg_ps = 2'b00;
    logic [1:0] ps;
    logic       uninit, d3cold, chg_flag, irq_en, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model: 0 uninit D0, 1 D0 active, 2 D1, 3 D2, 4 D3hot, 5 D3cold
    int m_st = 0;
    bit m_flag = 1'b0;
    bit m_en = 1'b0;

    always #10 clk = ~clk;

    pci_pm_tracker dut_i (.*);

    function automatic logic [1:0] code_of(int s);
        case (s)
            2: return 2'b01;
            3: return 2'b10;
            4, 5: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic void model_step(bit br, bit hr, bit vc, bit wr, logic [1:0] wd,
                                       bit si, bit cl, bit ew, bit ed);
        bit set = 1'b0;
        if (br || hr) begin
            m_st = 0; m_flag = 1'b0; m_en = 1'b0;
        end else begin
            if (vc) m_st = 5;
            else if (m_st != 5 && wr && wd != code_of(m_st)) begin
                set = 1'b1;
                if (wd == 2'b01) m_st = 2;
                else if (wd == 2'b10) m_st = 3;
                else if (wd == 2'b11) m_st = 4;
                else m_st = (m_st == 4) ? 0 : 1;
            end else if (si && m_st == 0) m_st = 1;
            if (set) m_flag = 1'b1;
            else if (cl) m_flag = 1'b0;
            if (ew) m_en = ed;
        end
    endfunction

    task automatic chk1(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        chk1({"R3 ", ctx}, "ps", ps, code_of(m_st));
        chk1({"R2 ", ctx}, "uninit", uninit, m_st == 0);
        chk1({"R8 ", ctx}, "d3cold", d3cold, m_st == 5);
        chk1({"R5 ", ctx}, "chg_flag", chg_flag, m_flag);
        chk1({"R7 ", ctx}, "irq_en", irq_en, m_en);
        chk1({"R7 ", ctx}, "irq", irq, m_flag && m_en);
    endtask

    // drive one cycle at the falling edge, check at the next falling edge
    task automatic cyc(string ctx, bit br, bit hr, bit vc, bit wr, logic [1:0] wd,
                       bit si, bit cl, bit ew, bit ed);
        bus_rst = br; ctrl_rst = hr; vcc_cut = vc; cfg_wr = wr; cfg_ps = wd;
        sw_init = si; clr_wr = cl; irq_en_wr = ew; irq_en_wdata = ed;
        model_step(br, hr, vc, wr, wd, si, cl, ew, ed);
        @(posedge clk);
        @(negedge clk);
        check_all(ctx);
        bus_rst = 0; ctrl_rst = 0; vcc_cut = 0; cfg_wr = 0; sw_init = 0;
        clr_wr = 0; irq_en_wr = 0;
    endtask

    task automatic goto_state(int s);
        cyc("R1 setup", 1, 0, 0, 0, 2'b00, 0, 0, 0, 0);
        case (s)
            1: cyc("R2 setup", 0, 0, 0, 0, 2'b00, 1, 0, 0, 0);
            2: cyc("R3 setup", 0, 0, 0, 1, 2'b01, 0, 0, 0, 0);
            3: cyc("R3 setup", 0, 0, 0, 1, 2'b10, 0, 0, 0, 0);
            4: cyc("R3 setup", 0, 0, 0, 1, 2'b11, 0, 0, 0, 0);
            default: ;
        endcase
        cyc("R6 setup", 0, 0, 0, 0, 2'b00, 0, 1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_all("R1 power-on");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // sweep: start state x written code x sw_init x clear, enable toggling
        for (int s = 0; s < 5; s++) begin
            for (int wd = 0; wd < 4; wd++) begin
                for (int si = 0; si < 2; si++) begin
                    for (int cl = 0; cl < 2; cl++) begin
                        goto_state(s);
                        cyc("R7 enable", 0, 0, 0, 0, 2'b00, 0, 0, 1, (wd + si) % 2);
                        cyc("R4 R5 R6 sweep", 0, 0, 0, 1, 2'(wd), si, cl, 0, 0);
                        cyc("R2 lone init", 0, 0, 0, 0, 2'b00, si, 0, 0, 0);
                        cyc("R5 repeat write", 0, 0, 0, 1, 2'(wd), 0, 0, 0, 0);
                        cyc("R6 clear", 0, 0, 0, 0, 2'b00, 0, 1, 0, 0);
                    end
                end
            end
        end

        // R8: supply loss from every state, writes and init ignored afterwards
        for (int s = 0; s < 5; s++) begin
            goto_state(s);
            cyc("R8 vcc vs write", 0, 0, 1, 1, 2'b01, 1, 0, 0, 0);
            for (int wd = 0; wd < 4; wd++)
                cyc("R8 write ignored", 0, 0, 0, 1, 2'(wd), 1, 0, 0, 0);
            cyc("R8 stays cold", 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
            cyc("R1 ctrl reset exits", 0, 1, 0, 0, 2'b00, 0, 0, 0, 0);
        end

        // R8: flag kept across supply loss, cleared by local clear
        goto_state(2);
        cyc("R5 set", 0, 0, 0, 1, 2'b10, 0, 0, 1, 1);
        cyc("R8 flag kept", 0, 0, 1, 0, 2'b00, 0, 0, 0, 0);
        cyc("R6 clear in cold", 0, 0, 0, 0, 2'b00, 0, 1, 0, 0);

        // R9: reset beats supply loss in the same cycle
        cyc("R9 bus reset vs vcc", 1, 0, 1, 1, 2'b11, 1, 0, 1, 1);
        cyc("R9 ctrl reset vs vcc", 0, 1, 1, 0, 2'b00, 0, 0, 0, 0);

        // R1: async reset in D3hot with flag and enable set
        goto_state(4);
        cyc("R7 enable", 0, 0, 0, 1, 2'b10, 0, 0, 1, 1);
        rst_n = 1'b0;
        m_st = 0; m_flag = 1'b0; m_en = 1'b0;
        #3;
        check_all("R1 async");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 async release");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule